// File: doc/BRIEF.md
# SPI slave register interface

This block lets an external SPI master read and write a small register bank over a four-wire mode 0 link. It holds four control registers that it drives out on parallel ports, and four status registers that capture raw flag inputs as sticky bits. A packet begins with a command/address byte. A write adds one data byte, and a read is answered in the byte that follows it. The reply shift register is reloaded only when a byte completes, so each reply byte carries the register named by the previous command. A write takes effect only when CS returns high, and only if the packet held exactly sixteen clocks.

Status flags collect only while CS is high, so a transfer always reads a frozen snapshot. Reading a status register clears it when the packet ends. Each status byte carries a parity bit in its top position. The error output reports any latched status bit and is also frozen while CS is low.

The SPI pins are sampled by the system clock through two-stage synchronisers, and all logic runs in that domain. The SPI clock must therefore stay well below the system clock: each SPI clock phase must last at least four system clock cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: The link works in SPI mode 0 with MSB first. DI is taken on the rising CLK edge, DO moves only after a falling CLK edge, and CS is active low.
- R2: The first byte of a packet holds a command in bits 7:5 and a register address in bits 4:0. The byte shifted out during any byte is the content of the register addressed by the most recent command byte, captured when the previous byte ended. During the data byte of a write, DO returns the old content of the target register.
- R3: Command 3'b100 (write) stores the second byte into the addressed control register only when CS rises, never while CS is still low.
- R4: A write is stored only if exactly 16 CLK rising edges occurred while CS was low. With 15 or 17 edges the control register keeps its value.
- R5: A write that addresses a status register (addresses 4 to 7) leaves that register unchanged.
- R6: Status registers sit at addresses 4 to 7, and status register k takes raw flags stat_flags_i[7k+6:7k] into bits 6:0. Bit 7 is 1 when bits 6:0 hold an odd number of ones. Control registers sit at addresses 0 to 3 and read back all eight bits without parity.
- R7: Status bits are sticky and are updated only while CS is high. A flag raised and dropped while CS is low is not latched, and a read inside a packet returns the value latched before CS fell.
- R8: A status register read by command 3'b000 within a packet is cleared when that packet's CS rises. A raw flag still high at that moment is latched again in the cycle after the clear.
- R9: err_o is high when any status bit is latched. It changes only while CS is high.
- R10: After reset, all control outputs, all status registers, err_o and DO are zero.
- R11: A read of an unmapped address (8 to 31) returns zero. A command code other than 3'b000 or 3'b100 writes nothing, but its address still selects the next reply byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI clock, idles low |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |
| stat_flags_i | input | 28 | Raw status flags, 7 per status register |
| ctrl_o | output | 32 | Control registers, register j at bits 8j+7:8j |
| err_o | output | 1 | Any status bit latched |

## Verification
The clear-on-read of a status register and the re-latching of its raw flag both fall on the CS rising edge. The bench provokes this collision by raising a flag just after CS falls, reading that register in the same packet, and holding the flag high through the end of the packet. The in-packet reply must show the cleared snapshot. err_o must be high after the packet, and a second read must return the flag pattern with correct parity. This shows that the clear took effect first and the event was not lost.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int CMD_W = 3;
  typedef enum logic [CMD_W-1:0] {
    CMD_READ  = 3'b000,
    CMD_WRITE = 3'b100
  } cmd_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_hi_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic sdi_o
);
  logic [STAGES-1:0] cs_sync, sclk_sync, sdi_sync;
  logic cs_d, sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync   <= '1;
      sclk_sync <= '0;
      sdi_sync  <= '0;
      cs_d      <= 1'b1;
      sclk_d    <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[STAGES-2:0], cs_ni};
      sclk_sync <= {sclk_sync[STAGES-2:0], sclk_i};
      sdi_sync  <= {sdi_sync[STAGES-2:0], sdi_i};
      cs_d      <= cs_sync[STAGES-1];
      sclk_d    <= sclk_sync[STAGES-1];
    end
  end

  assign cs_hi_o     = cs_sync[STAGES-1];
  assign cs_rise_o   = cs_sync[STAGES-1] & ~cs_d;
  assign sclk_rise_o = sclk_sync[STAGES-1] & ~sclk_d & ~cs_sync[STAGES-1];
  assign sclk_fall_o = ~sclk_sync[STAGES-1] & sclk_d & ~cs_sync[STAGES-1];
  assign sdi_o       = sdi_sync[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 5,
  parameter int N_CTRL = 4,
  parameter int N_STAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_hi_i,
  input  logic              cs_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              sdo_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [N_STAT-1:0] clr_o
);
  localparam int BW = $clog2(DW);
  localparam int CW = $clog2(2*DW+1) + 1;
  localparam logic [CW-1:0] PKT_WR = CW'(2*DW);

  logic [DW-1:0]     rx_sh, tx_sh, data_q;
  logic [BW-1:0]     bit_idx;
  logic [CW-1:0]     pkt_cnt;
  logic [AW-1:0]     addr_q;
  logic              expect_data, wr_cmd_q;
  logic [N_STAT-1:0] rd_mask, rd_hit;
  logic              byte_done;
  cmd_e              cmd;

  assign byte_done = sclk_fall_i && (bit_idx == '0) && (pkt_cnt != '0);
  assign cmd       = cmd_e'(rx_sh[DW-1:AW]);
  assign rd_addr_o = (byte_done && !expect_data) ? rx_sh[AW-1:0] : addr_q;

  always_comb begin
    for (int j = 0; j < N_STAT; j++)
      rd_hit[j] = (rx_sh[AW-1:0] == AW'(N_CTRL + j));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh       <= '0;
      tx_sh       <= '0;
      data_q      <= '0;
      bit_idx     <= '0;
      pkt_cnt     <= '0;
      addr_q      <= '0;
      expect_data <= 1'b0;
      wr_cmd_q    <= 1'b0;
      rd_mask     <= '0;
    end else if (cs_hi_i) begin
      bit_idx     <= '0;
      pkt_cnt     <= '0;
      expect_data <= 1'b0;
      wr_cmd_q    <= 1'b0;
      rd_mask     <= '0;
    end else begin
      if (sclk_rise_i) begin
        rx_sh   <= {rx_sh[DW-2:0], sdi_i};
        bit_idx <= bit_idx + 1'b1;
        if (pkt_cnt != '1) pkt_cnt <= pkt_cnt + 1'b1;
      end
      if (sclk_fall_i) begin
        if (byte_done) tx_sh <= rd_data_i;
        else           tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
      if (byte_done) begin
        if (expect_data) begin
          data_q      <= rx_sh;
          expect_data <= 1'b0;
        end else begin
          addr_q <= rx_sh[AW-1:0];
          if (cmd == CMD_WRITE) begin
            expect_data <= 1'b1;
            wr_cmd_q    <= (pkt_cnt == CW'(DW));
          end
          if (cmd == CMD_READ) rd_mask <= rd_mask | rd_hit;
        end
      end
    end
  end

  assign sdo_o     = tx_sh[DW-1];
  assign wr_en_o   = cs_rise_i && wr_cmd_q && (pkt_cnt == PKT_WR);
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
  assign clr_o     = cs_rise_i ? rd_mask : '0;

  AST_TX_ONLY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall_i |=> $stable(tx_sh)) else $error("tx moved without CLK fall"); // R1
  AST_NO_EDGE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |=> $stable(rx_sh)) else $error("rx shifted while CS high"); // R1
  AST_WR_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> cs_rise_i && !expect_data) else $error("write outside CS rise"); // R3
endmodule

// File: rtl/spi_ctrl_bank.sv
module spi_ctrl_bank #(
  parameter int DW     = 8,
  parameter int AW     = 5,
  parameter int N_CTRL = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic [N_CTRL*DW-1:0] ctrl_o
);
  for (genvar j = 0; j < N_CTRL; j++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_o[j*DW +: DW] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(j)) ctrl_o[j*DW +: DW] <= wr_data_i;
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_o)) else $error("control changed without write"); // R3
endmodule

// File: rtl/spi_stat_bank.sv
module spi_stat_bank #(
  parameter int DW     = 8,
  parameter int N_STAT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_hi_i,
  input  logic                 cs_rise_i,
  input  logic [N_STAT*(DW-1)-1:0] flags_i,
  input  logic [N_STAT-1:0]    clr_i,
  output logic [N_STAT*DW-1:0] stat_o,
  output logic                 err_o
);
  localparam int FW = DW - 1;
  logic [N_STAT-1:0][FW-1:0] stat_q;
  logic upd;

  // clear wins on the CS rise cycle; collection resumes one cycle later
  assign upd = cs_hi_i & ~cs_rise_i;

  for (genvar j = 0; j < N_STAT; j++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 stat_q[j] <= '0;
      else if (cs_rise_i && clr_i[j]) stat_q[j] <= '0;
      else if (upd)                stat_q[j] <= stat_q[j] | flags_i[j*FW +: FW];
    end
    assign stat_o[j*DW +: DW] = {^stat_q[j], stat_q[j]};

    AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_rise_i && clr_i[j]) |=> stat_q[j] == '0) else $error("read status not cleared"); // R8
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_o <= 1'b0;
    else if (cs_hi_i) err_o <= |stat_q;
  end

  AST_STAT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_hi_i |=> $stable(stat_q)) else $error("status moved with CS low"); // R7
  AST_ERR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_hi_i |=> $stable(err_o)) else $error("err moved with CS low"); // R9
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int DW     = 8,
  parameter int AW     = 5,
  parameter int N_CTRL = 4,
  parameter int N_STAT = 4,
  parameter int SYNC   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  input  logic [N_STAT*(DW-1)-1:0] stat_flags_i,
  output logic [N_CTRL*DW-1:0]     ctrl_o,
  output logic                     err_o
);
  logic cs_hi, cs_rise, sclk_rise, sclk_fall, sdi_s, wr_en;
  logic [AW-1:0]        rd_addr, wr_addr;
  logic [DW-1:0]        rd_data, wr_data;
  logic [N_STAT-1:0]    clr;
  logic [N_STAT*DW-1:0] stat_bytes;

  spi_pin_sync #(.STAGES(SYNC)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i,
    .cs_hi_o(cs_hi), .cs_rise_o(cs_rise), .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall), .sdi_o(sdi_s)
  );

  spi_frame #(.DW(DW), .AW(AW), .N_CTRL(N_CTRL), .N_STAT(N_STAT)) i_frame (
    .clk_i, .rst_ni, .cs_hi_i(cs_hi), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .sdi_i(sdi_s),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .sdo_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .clr_o(clr)
  );

  spi_ctrl_bank #(.DW(DW), .AW(AW), .N_CTRL(N_CTRL)) i_ctrl (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ctrl_o
  );

  spi_stat_bank #(.DW(DW), .N_STAT(N_STAT)) i_stat (
    .clk_i, .rst_ni, .cs_hi_i(cs_hi), .cs_rise_i(cs_rise),
    .flags_i(stat_flags_i), .clr_i(clr), .stat_o(stat_bytes), .err_o
  );

  // read mux: control, then status, unmapped reads zero
  always_comb begin
    rd_data = '0;
    for (int j = 0; j < N_CTRL; j++)
      if (rd_addr == AW'(j)) rd_data = ctrl_o[j*DW +: DW];
    for (int j = 0; j < N_STAT; j++)
      if (rd_addr == AW'(N_CTRL + j)) rd_data = stat_bytes[j*DW +: DW];
  end
endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, err;
  logic [27:0] flags = '0;
  logic [31:0] ctrl;
  int checks = 0, errors = 0;
  logic [7:0] ctrl_m [4];

  always #10 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .stat_flags_i(flags), .ctrl_o(ctrl), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] par_byte(input logic [6:0] f);
    int n = 0;
    for (int i = 0; i < 7; i++) n += f[i];
    return {n[0], f};
  endfunction

  task automatic cs_lo();
    @(negedge clk) cs_n = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_up();
    repeat (8) @(negedge clk);
    cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic shift(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      sdi = tx[7-i];
      repeat (8) @(negedge clk);
      rx = {rx[6:0], sdo};
      sclk = 1;
      repeat (8) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] b0, output logic [7:0] b1);
    cs_lo();
    shift({3'b000, a}, 8, b0);
    shift(8'h00, 8, b1);
    cs_up();
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, output logic [7:0] old);
    logic [7:0] b0;
    cs_lo();
    shift({3'b100, a}, 8, b0);
    shift(d, 8, old);
    cs_up();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b0, b1, b2, old;
    logic [6:0] p;
    for (int k = 0; k < 4; k++) ctrl_m[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 ctrl reset", ctrl, 0);
    chk("R10 err reset", {31'd0, err}, 0);
    chk("R10 sdo reset", {31'd0, sdo}, 0);
    rd(5'd4, b0, b1);
    chk("R10 status reset", b1, 0);

    // R3 R2: write sweep, old value returned on data byte, readback
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        v = 8'((i * 37 + k * 11 + 5) & 255);
        wr(5'(k), v, old);
        chk("R2 old data on write", old, ctrl_m[k]);
        ctrl_m[k] = v;
        chk("R3 ctrl after write", ctrl, {ctrl_m[3], ctrl_m[2], ctrl_m[1], ctrl_m[0]});
      end
    end
    for (int k = 0; k < 4; k++) begin
      rd(5'(k), b0, b1);
      chk("R1 control readback", b1, ctrl_m[k]);
    end

    // R3: not committed while CS still low
    cs_lo();
    shift(8'h82, 8, b0);
    shift(8'hC3, 8, b1);
    repeat (12) @(negedge clk);
    chk("R3 no commit before CS rise", ctrl[23:16], ctrl_m[2]);
    cs_up();
    ctrl_m[2] = 8'hC3;
    chk("R3 commit at CS rise", ctrl[23:16], 8'hC3);

    // R2: after a write the next read's first byte is the old value again
    wr(5'd1, 8'h5A, old);
    rd(5'd1, b0, b1);
    chk("R2 lag first byte", b0, ctrl_m[1]);
    ctrl_m[1] = 8'h5A;
    chk("R2 read new", b1, 8'h5A);

    // R2: chained reads, reply lags one command
    cs_lo();
    shift(8'h00, 8, b0);
    shift(8'h03, 8, b1);
    shift(8'h00, 8, b2);
    cs_up();
    chk("R2 chain byte2", b1, ctrl_m[0]);
    chk("R2 chain byte3", b2, ctrl_m[3]);

    // R4: 15 and 17 bit writes ignored
    cs_lo();
    shift(8'h80, 8, b0);
    shift(8'hFF, 7, b1);
    cs_up();
    chk("R4 15-bit write ignored", ctrl[7:0], ctrl_m[0]);
    cs_lo();
    shift(8'h80, 8, b0);
    shift(8'hEE, 8, b1);
    shift(8'h00, 1, b2);
    cs_up();
    chk("R4 17-bit write ignored", ctrl[7:0], ctrl_m[0]);

    // R11: unmapped read, unknown command
    rd(5'd20, b0, b1);
    chk("R11 unmapped read zero", b1, 0);
    cs_lo();
    shift(8'h41, 8, b0);
    shift(8'h99, 8, b1);
    cs_up();
    chk("R11 unknown cmd reply", b1, ctrl_m[1]);
    chk("R11 unknown cmd no write", ctrl, {ctrl_m[3], ctrl_m[2], ctrl_m[1], ctrl_m[0]});

    // R6 R8 R9: full pattern sweep on status register 0
    for (int v = 0; v < 128; v++) begin
      p = 7'(v);
      @(negedge clk) flags = {21'd0, p};
      repeat (6) @(negedge clk);
      flags = '0;
      repeat (4) @(negedge clk);
      chk("R9 err set", {31'd0, err}, {31'd0, (p != 0)});
      rd(5'd4, b0, b1);
      chk("R6 status parity", b1, par_byte(p));
      chk("R8 err cleared after read", {31'd0, err}, 0);
    end
    // other status registers and field positions
    for (int k = 1; k < 4; k++) begin
      for (int v = 1; v < 128; v += 9) begin
        p = 7'(v);
        @(negedge clk) flags = 28'(p) << (7 * k);
        repeat (6) @(negedge clk);
        flags = '0;
        rd(5'(4 + k), b0, b1);
        chk("R6 status field", b1, par_byte(p));
      end
    end
    // R8 sticky until read
    @(negedge clk) flags = 28'h1 << 14;
    repeat (3) @(negedge clk);
    flags = '0;
    rd(5'd4, b0, b1);
    chk("R8 other reg unaffected", b1, 0);
    rd(5'd6, b0, b1);
    chk("R8 sticky", b1, par_byte(7'h01));
    rd(5'd6, b0, b1);
    chk("R8 cleared by read", b1, 0);

    // R5: write to status ignored
    @(negedge clk) flags = 28'h3 << 7;
    repeat (3) @(negedge clk);
    flags = '0;
    wr(5'd5, 8'h7F, old);
    rd(5'd5, b0, b1);
    chk("R5 status write ignored", b1, par_byte(7'h03));

    // R7 R8: raise flag while CS low, read same reg in packet, hold through CS rise
    cs_lo();
    flags = 28'h55 << 14;
    repeat (10) @(negedge clk);
    shift(8'h06, 8, b0);
    shift(8'h00, 8, b1);
    chk("R7 frozen while CS low", b1, 0);
    chk("R9 err frozen while CS low", {31'd0, err}, 0);
    cs_up();
    flags = '0;
    repeat (3) @(negedge clk);
    chk("R8 relatch after clear", {31'd0, err}, 1);
    rd(5'd6, b0, b1);
    chk("R8 relatched value", b1, par_byte(7'h55));

    // R7: pulse entirely inside CS low is lost
    cs_lo();
    flags = 28'h7F;
    repeat (10) @(negedge clk);
    flags = '0;
    cs_up();
    rd(5'd4, b0, b1);
    chk("R7 pulse while CS low lost", b1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule